// File: doc/BRIEF.md
# Multi-format serial audio frame receiver

This block receives serial audio as a slave. The bit clock, the frame clock and three data lines come from outside. The block oversamples them with its own system clock. It finds the rising edges of the bit clock and rebuilds the frame structure from the frame-clock level seen at each of those edges. Each completed frame yields six 24-bit samples on one wide output bus, with a one-cycle strobe.

A 3-bit configuration input selects the framing:

| Code | Format |
|------|--------|
| 000 | Left-justified, 24-bit |
| 001 | I2S, 24-bit |
| 010 | Right-justified, 16-bit |
| 011 | Right-justified, 24-bit |
| 100 | Six channels on one line, 20-bit slots |
| 101 | Six channels on one line, 24-bit slots |
| 110 | Eight-slot TDM, 32-bit slots |
| 111 | Reserved, behaves as 001 |

In the three stereo-line formats, line n carries channel An in the left half and Bn in the right half. Any word shorter than 24 bits leaves the block left-aligned, with zeros below it.

Top module: `audio_frame_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, `smp_valid` is 0 and `smp_data` is all zeros.
- R2: Data and frame-clock levels are taken at rising bit-clock edges, most significant bit first. A half frame starts at the bit-clock rise where the frame-clock level differs from its level at the previous rise. That rise carries bit index 0 of the new half.
- R3: Output slot k occupies `smp_data[24k+23:24k]`, with k = 0..5 meaning A1, A2, A3, B1, B2, B3. In code 000 the left half has the frame clock high, and the word's MSB is bit index 0.
- R4: In codes 001 and 111 the left half has the frame clock low, and the MSB is bit index 1.
- R5: In codes 010 and 011 the word is made of the last 16 or 24 bits before the half ends. A 16-bit word is output as bits 23:8, with bits 7:0 zero.
- R6: In codes 000, 001 and 111, a half shorter than the word gives only the bits received, with zeros in the missing low bits. This applies to 16 or 24 bit clocks per half.
- R7: Code 100 uses line 0 only, with the left half at frame clock high. The left half carries A1, A2, A3 and the right half carries B1, B2, B3. The slots start at bit indices 0, 20 and 40, and each is 20 bits. Output bits 3:0 are zero, and bits from index 60 on are ignored.
- R8: Code 101 works like code 100, but the slots are 24 bits wide and start at indices 0, 24 and 48.
- R9: In code 110, a frame starts at a frame-clock rise, and falls of the frame clock are ignored. Slot s (s = 0..5) starts at bit index 32s, and its first 24 bits form output slot s. Slots 6 and 7, and bits 24..31 of every slot, are ignored.
- R10: After each complete frame, `smp_valid` is high for exactly one cycle. In the stereo and one-line formats, a complete frame is a full left half followed by a full right half. `smp_data` changes only in the cycle where `smp_valid` is high.
- R11: After reset or a change of format code, any partial frame is discarded. No strobe comes until a full new frame has been received.
- R12: Lines 1 and 2 have no effect in codes 100, 101 and 110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 3 | Framing format code |
| bclk | input | 1 | External bit clock |
| fclk | input | 1 | External frame clock |
| sdin | input | 3 | Serial data lines |
| smp_valid | output | 1 | One-cycle strobe, new samples on `smp_data` |
| smp_data | output | 144 | Six 24-bit samples, slot 0 in the low bits |

## Verification
The hardest state to reach is a switch of format code just after a full left half and part of a right half, when the new format uses the same left polarity. A receiver without resynchronisation would pair that stale left half with the first new boundary and emit a strobe of junk. The bench builds exactly that tail and then opens a new stream at once. It also drives halves shorter than a word, at 16 and 24 bit clocks. Random bits fill every padding position and every unused line, so any decode slip shows up as a wrong sample.

// File: rtl/afr_pkg.sv
package afr_pkg;

    localparam int NLINE   = 3;
    localparam int NCH     = 2 * NLINE;
    localparam int WORD    = 24;
    localparam int IDXW    = 9;
    localparam int SLOTW   = $clog2(NCH + 2);
    localparam int POSW    = $clog2(WORD + 8);
    localparam int TDM_SW  = 32;
    localparam int TDM_LEN = 256;
    localparam int RJ_SHORT = 16;

    typedef enum logic [2:0] {
        FMT_LJ24  = 3'd0,
        FMT_I2S24 = 3'd1,
        FMT_RJ16  = 3'd2,
        FMT_RJ24  = 3'd3,
        FMT_OL20  = 3'd4,
        FMT_OL24  = 3'd5,
        FMT_TDM32 = 3'd6,
        FMT_RSVD  = 3'd7
    } fmt_e;

    typedef logic [WORD-1:0] word_t;

    typedef struct packed {
        logic             en;
        logic [SLOTW-1:0] slot;
        logic [POSW-1:0]  pos;
    } place_t;

    // one bit-clock event as seen by the unpacker
    typedef struct packed {
        logic             ev;
        logic             bnd;
        logic             close;
        logic             close_right;
        logic             right;
        logic             resync;
        logic [IDXW-1:0]  idx;
        logic [NLINE-1:0] sd;
    } tick_t;

    function automatic logic is_i2s(fmt_e f);
        return (f == FMT_I2S24) || (f == FMT_RSVD);
    endfunction

    function automatic logic is_rj(fmt_e f);
        return (f == FMT_RJ16) || (f == FMT_RJ24);
    endfunction

    function automatic logic is_serial(fmt_e f);
        return (f == FMT_OL20) || (f == FMT_OL24) || (f == FMT_TDM32);
    endfunction

    // frame-clock level that marks the left half
    function automatic logic left_level(fmt_e f);
        return !is_i2s(f);
    endfunction

    function automatic word_t rj_align(fmt_e f, word_t sh);
        if (f == FMT_RJ16)
            return {sh[RJ_SHORT-1:0], {(WORD-RJ_SHORT){1'b0}}};
        return sh;
    endfunction

    function automatic place_t place_stereo(fmt_e f, logic [IDXW-1:0] idx,
                                            logic right, int line);
        place_t p;
        int k;
        k      = int'(idx) - (is_i2s(f) ? 1 : 0);
        p.en   = (k >= 0) && (k < WORD);
        p.pos  = POSW'(k);
        p.slot = SLOTW'(line + (right ? NLINE : 0));
        return p;
    endfunction

    function automatic place_t place_serial(fmt_e f, logic [IDXW-1:0] idx,
                                            logic right);
        place_t p;
        int i;
        int w;
        int s;
        int k;
        i = int'(idx);
        p = '0;
        if (f == FMT_TDM32) begin
            s = i / TDM_SW;
            k = i % TDM_SW;
            p.en   = (i < TDM_LEN) && (s < NCH) && (k < WORD);
            p.slot = SLOTW'(s);
            p.pos  = POSW'(k);
        end else begin
            w = (f == FMT_OL20) ? 20 : WORD;
            if (i < w) begin
                s = 0; k = i;
            end else if (i < 2 * w) begin
                s = 1; k = i - w;
            end else begin
                s = 2; k = i - 2 * w;
            end
            p.en   = (i < NLINE * w);
            p.slot = SLOTW'(s + (right ? NLINE : 0));
            p.pos  = POSW'(k);
        end
        return p;
    endfunction

endpackage

// File: rtl/afr_sync.sv
module afr_sync #(
    parameter int STAGES = 2,
    parameter int W      = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         rise0
);
    logic [STAGES-1:0][W-1:0] st;
    logic                     last0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            last0 <= 1'b0;
        end else begin
            st[0] <= din;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            last0 <= st[STAGES-1][0];
        end
    end

    assign dout  = st[STAGES-1];
    assign rise0 = st[STAGES-1][0] & ~last0;

    // R2: a bit-clock rise is a single-cycle event
    a_r2_rise_gap: assert property (@(posedge clk) disable iff (rst)
        rise0 |=> !rise0);

endmodule

// File: rtl/afr_framer.sv
module afr_framer
    import afr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  fmt_e             fmt,
    input  logic             rise,
    input  logic             fck,
    input  logic [NLINE-1:0] sd,
    output tick_t            tk
);
    fmt_e            fmt_q;
    logic            fck_q;
    logic            primed;
    logic            synced;
    logic            right_q;
    logic [IDXW-1:0] idx_q;

    logic chg;
    logic bnd;
    logic new_right;

    always_comb begin
        chg       = (fmt != fmt_q);
        new_right = (fmt == FMT_TDM32) ? 1'b1 : (fck != left_level(fmt));
        bnd       = rise && !chg && primed && (fck != fck_q) &&
                    ((fmt == FMT_TDM32) ? fck : 1'b1);
        tk.ev          = rise && !chg && primed && (synced || bnd);
        tk.bnd         = bnd;
        tk.close       = bnd && synced;
        tk.close_right = right_q;
        tk.right       = bnd ? new_right : right_q;
        tk.resync      = chg;
        tk.idx         = bnd ? '0 : idx_q;
        tk.sd          = sd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q   <= fmt;
            fck_q   <= 1'b0;
            primed  <= 1'b0;
            synced  <= 1'b0;
            right_q <= 1'b0;
            idx_q   <= '0;
        end else if (chg) begin
            fmt_q  <= fmt;
            primed <= 1'b0;
            synced <= 1'b0;
        end else if (rise) begin
            fck_q  <= fck;
            primed <= 1'b1;
            if (bnd) begin
                synced  <= 1'b1;
                right_q <= new_right;
                idx_q   <= IDXW'(1);
            end else if (idx_q != '1) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/afr_unpack.sv
module afr_unpack
    import afr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  fmt_e                fmt,
    input  tick_t               tk,
    output logic                vld,
    output logic [NCH*WORD-1:0] smp
);
    word_t acc [NCH];
    word_t fin [NCH];
    word_t nxt [NCH];
    logic [NLINE-1:0][WORD-1:0] rj_w;
    logic   left_ok;
    logic   frame_done;
    place_t ps;
    place_t pst;

    // per-line shift register holding the most recent bits of the half
    for (genvar g = 0; g < NLINE; g++) begin : g_line
        word_t sh;
        always_ff @(posedge clk) begin
            if (rst)         sh <= '0;
            else if (tk.bnd) sh <= {{(WORD-1){1'b0}}, tk.sd[g]};
            else if (tk.ev)  sh <= {sh[WORD-2:0], tk.sd[g]};
        end
        assign rj_w[g] = rj_align(fmt, sh);
    end

    always_comb begin
        ps  = '0;
        pst = '0;
        for (int c = 0; c < NCH; c++) fin[c] = acc[c];
        if (tk.close && is_rj(fmt))
            for (int l = 0; l < NLINE; l++)
                fin[l + (tk.close_right ? NLINE : 0)] = rj_w[l];

        for (int c = 0; c < NCH; c++) begin
            nxt[c] = fin[c];
            if (tk.bnd && ((fmt == FMT_TDM32) || ((c >= NLINE) == tk.right)))
                nxt[c] = '0;
        end

        if (tk.ev && !is_rj(fmt)) begin
            if (is_serial(fmt)) begin
                ps = place_serial(fmt, tk.idx, tk.right);
                if (ps.en) nxt[ps.slot][WORD-1-int'(ps.pos)] = tk.sd[0];
            end else begin
                for (int l = 0; l < NLINE; l++) begin
                    pst = place_stereo(fmt, tk.idx, tk.right, l);
                    if (pst.en) nxt[pst.slot][WORD-1-int'(pst.pos)] = tk.sd[l];
                end
            end
        end

        frame_done = tk.close &&
                     ((fmt == FMT_TDM32) || (tk.close_right && left_ok));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) acc[c] <= '0;
            left_ok <= 1'b0;
            vld     <= 1'b0;
            smp     <= '0;
        end else begin
            for (int c = 0; c < NCH; c++) acc[c] <= nxt[c];
            vld <= frame_done;
            if (frame_done)
                for (int c = 0; c < NCH; c++) smp[c*WORD +: WORD] <= fin[c];
            if (tk.resync)     left_ok <= 1'b0;
            else if (tk.close) left_ok <= !tk.close_right;
        end
    end

    // R10: strobe lasts one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

    // R10: samples only move together with the strobe
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !vld |-> $stable(smp));

    // R10: a stereo or one-line frame needs its left half first
    a_r10_left_first: assert property (@(posedge clk) disable iff (rst)
        (vld && $past(fmt) != FMT_TDM32) |-> $past(left_ok));

endmodule

// File: rtl/audio_frame_rx.sv
module audio_frame_rx
    import afr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          fmt_sel,
    input  logic                bclk,
    input  logic                fclk,
    input  logic [NLINE-1:0]    sdin,
    output logic                smp_valid,
    output logic [NCH*WORD-1:0] smp_data
);
    localparam int SYNC_W = NLINE + 2;

    fmt_e              fmt;
    logic [SYNC_W-1:0] raw;
    logic [SYNC_W-1:0] synced;
    logic              rise;
    tick_t             tk;

    assign fmt = fmt_e'(fmt_sel);
    assign raw = {sdin, fclk, bclk};

    afr_sync #(.STAGES(SYNC_STAGES), .W(SYNC_W)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw),
        .dout (synced),
        .rise0(rise)
    );

    afr_framer u_framer (
        .clk (clk),
        .rst (rst),
        .fmt (fmt),
        .rise(rise),
        .fck (synced[1]),
        .sd  (synced[SYNC_W-1:2]),
        .tk  (tk)
    );

    afr_unpack u_unpack (
        .clk(clk),
        .rst(rst),
        .fmt(fmt),
        .tk (tk),
        .vld(smp_valid),
        .smp(smp_data)
    );

    // R11: a format change never produces a strobe on the next cycle
    a_r11_resync_quiet: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel != $past(fmt_sel)) |=> !smp_valid);

endmodule

// File: tb/audio_frame_rx_bench.sv
module audio_frame_rx_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   fmt_sel = 3'd0;
    logic         bclk = 1'b0;
    logic         fclk = 1'b0;
    logic [2:0]   sdin = 3'd0;
    logic         smp_valid;
    logic [143:0] smp_data;

    always #4 clk = ~clk;

    audio_frame_rx u_audio_frame_rx (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .bclk(bclk), .fclk(fclk),
        .sdin(sdin), .smp_valid(smp_valid), .smp_data(smp_data)
    );

    int checks = 0;
    int fails  = 0;
    int stray  = 0;
    int cyc    = 0;
    bit finished = 0;
    logic [23:0] expq[$];
    string tagq[$];
    logic [143:0] prev_data = '0;
    logic prev_valid = 1'b0;

    function automatic bit i2s_like(int f);
        return (f == 1) || (f == 7);
    endfunction

    function automatic bit left_lvl(int f);
        return !i2s_like(f);
    endfunction

    function automatic logic [23:0] expect_word(int f, int hb, logic [23:0] s);
        int keep;
        case (f)
            0:       keep = (hb < 24) ? hb : 24;
            1, 7:    keep = (hb - 1 < 24) ? hb - 1 : 24;
            2:       keep = 16;
            4:       keep = 20;
            default: keep = 24;
        endcase
        return s & (24'hFFFFFF << (24 - keep));
    endfunction

    function automatic bit src_bit(int f, bit right, int line, int idx, int hb,
                                   logic [23:0] s[6]);
        int ch, k, w, n;
        bit noise;
        noise = bit'($urandom % 2);
        if (f == 6) begin
            if (line != 0) return noise;
            ch = idx / 32; k = idx % 32;
            if (ch < 6 && k < 24) return s[ch][23-k];
            return noise;
        end
        if (f == 4 || f == 5) begin
            if (line != 0) return noise;
            w = (f == 4) ? 20 : 24;
            if (idx >= 3 * w) return noise;
            ch = idx / w + (right ? 3 : 0);
            return s[ch][23 - (idx % w)];
        end
        ch = line + (right ? 3 : 0);
        if (f == 2 || f == 3) begin
            n = (f == 2) ? 16 : 24;
            k = idx - (hb - n);
        end else begin
            k = idx - (i2s_like(f) ? 1 : 0);
            n = 24;
        end
        if (k >= 0 && k < n) return s[ch][23-k];
        return noise;
    endfunction

    task automatic tick(bit f, logic [2:0] d);
        fclk = f;
        sdin = d;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
        bclk = 1'b0;
    endtask

    task automatic send_half(int f, bit right, int hb, logic [23:0] s[6]);
        logic [2:0] d;
        bit fl;
        for (int idx = 0; idx < hb; idx++) begin
            for (int l = 0; l < 3; l++) d[l] = src_bit(f, right, l, idx, hb, s);
            if (f == 6) fl = (idx == 0);
            else        fl = right ? !left_lvl(f) : left_lvl(f);
            tick(fl, d);
        end
    endtask

    task automatic run_stream(int f, int hb, int nframes, string tag, bit tail_long);
        logic [23:0] s[6];
        logic [23:0] junk[6];
        fmt_sel = 3'(f);
        for (int i = 0; i < 3; i++)
            tick((f == 6) ? 1'b0 : !left_lvl(f), 3'($urandom));
        for (int n = 0; n < nframes; n++) begin
            for (int c = 0; c < 6; c++) begin
                s[c] = 24'($urandom);
                expq.push_back(expect_word(f, (f == 6) ? 256 : hb, s[c]));
                tagq.push_back(tag);
            end
            if (f == 6) send_half(f, 1'b0, 256, s);
            else begin
                send_half(f, 1'b0, hb, s);
                send_half(f, 1'b1, hb, s);
            end
        end
        if (f == 6) begin
            tick(1'b1, 3'd0); tick(1'b0, 3'd0); tick(1'b0, 3'd0);
        end else if (tail_long) begin
            for (int c = 0; c < 6; c++) junk[c] = 24'($urandom);
            send_half(f, 1'b0, hb, junk);
            for (int i = 0; i < 5; i++) tick(!left_lvl(f), 3'($urandom));
        end else begin
            for (int i = 0; i < 3; i++) tick(left_lvl(f), 3'($urandom));
        end
        repeat (16) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // per-clock reference comparison
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (smp_valid) begin
                if (prev_valid) stray++;
                for (int c = 0; c < 6; c++) begin
                    checks++;
                    if (expq.size() == 0) begin
                        fails++;
                        $display("FAIL R11 unexpected strobe slot %0d: actual %h expected none",
                                 c, smp_data[c*24 +: 24]);
                    end else begin
                        logic [23:0] e;
                        string t;
                        e = expq.pop_front();
                        t = tagq.pop_front();
                        if (smp_data[c*24 +: 24] !== e) begin
                            fails++;
                            $display("FAIL %s slot %0d: actual %h expected %h",
                                     t, c, smp_data[c*24 +: 24], e);
                        end
                    end
                end
            end else if (smp_data !== prev_data) begin
                stray++;
            end
            prev_data  = smp_data;
            prev_valid = smp_valid;
        end
        if (cyc > 190000 && !finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (smp_valid !== 1'b0 || smp_data !== '0) begin
            fails++;
            $display("FAIL R1 reset: actual %b/%h expected 0/0", smp_valid, smp_data);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (smp_valid !== 1'b0 || smp_data !== '0) begin
            fails++;
            $display("FAIL R1 after reset: actual %b/%h expected 0/0", smp_valid, smp_data);
        end

        run_stream(0, 32, 3, "R3 LJ24 + R11 tail", 1'b1);
        run_stream(3, 32, 3, "R5 RJ24", 1'b0);
        run_stream(1, 32, 3, "R4 I2S24", 1'b0);
        run_stream(2, 32, 3, "R5 RJ16", 1'b0);
        run_stream(4, 64, 3, "R7 OL20 + R12", 1'b0);
        run_stream(5, 128, 2, "R8 OL24 + R12", 1'b0);
        run_stream(6, 256, 3, "R9 TDM + R12", 1'b0);
        run_stream(0, 16, 3, "R6 LJ24 short", 1'b0);
        run_stream(1, 24, 3, "R6 I2S24 short", 1'b0);
        run_stream(7, 32, 3, "R4 reserved code", 1'b0);
        run_stream(2, 128, 2, "R5 RJ16 long half", 1'b0);
        run_stream(0, 128, 2, "R2 R3 LJ24 long half", 1'b0);

        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R10 missing strobes: actual %0d words left expected 0", expq.size());
        end
        checks++;
        if (stray != 0) begin
            fails++;
            $display("FAIL R10 strobe/hold: actual %0d violations expected 0", stray);
        end
        finish_run();
    end

endmodule